// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block decides which of the output queues bound to one port may send next. Each queue holds a small priority code, written through a one-entry-per-cycle configuration port. A code of 1 to 8 is a weight. The weight is turned into a fixed 8-bit round mask, with its set bits spread evenly over eight repeating rounds. A queue joins only the rounds whose mask bit is set, so service follows the weight. A code of 0 takes the queue out of the arbitration altogether.

A code of 9 makes a queue static priority. Static queues must form one contiguous group that starts at queue 0. Any non-empty static queue is served before every weighted queue, and a lower index wins within the group. The block flags an invalid configuration. It does not buffer packets, meter rates or hold commands: it sees only per-queue non-empty flags and a grant/accept handshake.

Top module: `wrr_sched`

## Requirements
- R1: Codes 1..8 map to round masks 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff. In round r (0..7) a weighted queue is eligible only when mask bit r is set, so over eight rounds a weight-8 queue gets eight grants, a weight-4 queue four and a weight-1 queue one.
- R2: A queue with code 0 (mask 0x00) is never granted.
- R3: Code 9 marks a queue as static. When any static queue is non-empty, the lowest-indexed such queue is granted ahead of all weighted queues, and accepting it moves neither the round counter nor the pointer.
- R4: `cfg_err_o` is high while the static queues are not one contiguous group starting at index 0.
- R5: A code of 10..15 raises `cfg_err_o`, and that queue is treated as weighted with mask 0xff.
- R6: Within a round, weighted queues are granted in ascending index order from the pointer, each at most once per round. When no eligible queue remains at or above the pointer, `gnt_valid_o` is low for one cycle and the 3-bit round advances, wrapping 7→0, with the pointer back at 0. Accepting queue NQ-1 advances the round at once.
- R7: With inputs unchanged, an unaccepted grant keeps the same index.
- R8: `gnt_valid_o` is low in the same cycle when no queue is eligible.
- R9: `gnt_tail_o` is high when the granted queue is the last queue (NQ-1). `gnt_stail_o` is high when the granted queue is the last queue of the static group.
- R10: After reset all codes are 0 (masks 0x00), the round is 0 and the pointer is 0, so no grant is issued whatever the non-empty flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | $clog2(NQ) | Queue whose code is written |
| cfg_code_i | input | 4 | Priority code (0..8 weight, 9 static) |
| nonempty_i | input | NQ | Per-queue non-empty flags |
| accept_i | input | 1 | Consumer accepts the current grant |
| gnt_valid_o | output | 1 | A grant is offered |
| gnt_idx_o | output | $clog2(NQ) | Granted queue index |
| gnt_tail_o | output | 1 | Granted queue is the last queue |
| gnt_stail_o | output | 1 | Granted queue is the last static queue |
| cfg_err_o | output | 1 | Invalid priority configuration |

## Verification
A wrong round counter shows at the ports within one round sweep. A queue with a sparse mask is either granted in a round where its bit is clear or skipped in one where its bit is set, so the grant sequence over eight rounds departs from the 8:4:1 pattern of a mixed-weight setup. A pointer that fails to advance shows in the next cycle as a repeated index within a round. A pointer that moves on a static grant shows as a skipped weighted queue once the static queues drain. The bench compares the full grant sequence cycle by cycle, so any of these faults appears within about twenty cycles of its cause.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int unsigned ROUNDS  = 8;
  localparam int unsigned RW      = 3;
  localparam logic [3:0] CODE_STATIC = 4'd9;

  function automatic logic [ROUNDS-1:0] code_to_mask(input logic [3:0] code);
    case (code)
      4'd0:    return 8'h00;
      4'd1:    return 8'h01;
      4'd2:    return 8'h11;
      4'd3:    return 8'h49;
      4'd4:    return 8'h55;
      4'd5:    return 8'h57;
      4'd6:    return 8'h77;
      4'd7:    return 8'h7f;
      default: return 8'hff; // 8, static, and invalid codes
    endcase
  endfunction
endpackage

// File: rtl/wrr_cfg.sv
module wrr_cfg import wrr_pkg::*; #(
  parameter int unsigned NQ = 8,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [QW-1:0]         idx_i,
  input  logic [3:0]            code_i,
  output logic [ROUNDS-1:0]     mask_o [NQ],
  output logic [NQ-1:0]         stat_o,
  output logic [NQ-1:0]         stail_o,
  output logic                  err_o
);
  logic [NQ-1:0] bad_code;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [3:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           code_q <= '0;
      else if (we_i && idx_i == QW'(i))      code_q <= code_i;
    end
    assign mask_o[i]   = code_to_mask(code_q);
    assign stat_o[i]   = (code_q == CODE_STATIC);
    assign bad_code[i] = (code_q > CODE_STATIC);
    if (i == NQ - 1) begin : g_last
      assign stail_o[i] = stat_o[i];
    end else begin : g_mid
      assign stail_o[i] = stat_o[i] && (g_q[i+1].code_q != CODE_STATIC);
    end
  end

  logic [NQ-1:0] stat_inc;
  assign stat_inc = stat_o + NQ'(1);
  // static group must be a run of ones from bit 0
  assign err_o = (|bad_code) || ((stat_o & stat_inc) != '0);
endmodule

// File: rtl/wrr_first.sv
module wrr_first #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched import wrr_pkg::*; #(
  parameter int unsigned NQ = 8,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [QW-1:0] cfg_idx_i,
  input  logic [3:0]    cfg_code_i,
  input  logic [NQ-1:0] nonempty_i,
  input  logic          accept_i,
  output logic          gnt_valid_o,
  output logic [QW-1:0] gnt_idx_o,
  output logic          gnt_tail_o,
  output logic          gnt_stail_o,
  output logic          cfg_err_o
);
  logic [ROUNDS-1:0] mask [NQ];
  logic [NQ-1:0]     stat, stail;
  logic [RW-1:0]     round_q;
  logic [QW-1:0]     ptr_q;

  wrr_cfg #(.NQ(NQ)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .idx_i(cfg_idx_i), .code_i(cfg_code_i),
    .mask_o(mask), .stat_o(stat), .stail_o(stail), .err_o(cfg_err_o)
  );

  logic [NQ-1:0] s_req, w_req, w_pend;
  for (genvar i = 0; i < NQ; i++) begin : g_elig
    assign s_req[i]  = nonempty_i[i] && stat[i];
    assign w_pend[i] = nonempty_i[i] && !stat[i] && (mask[i] != '0);
    assign w_req[i]  = w_pend[i] && mask[i][round_q] && (QW'(i) >= ptr_q);
  end

  logic          s_hit, w_hit;
  logic [QW-1:0] s_idx, w_idx;
  wrr_first #(.N(NQ)) u_spick (.req_i(s_req), .found_o(s_hit), .idx_o(s_idx));
  wrr_first #(.N(NQ)) u_wpick (.req_i(w_req), .found_o(w_hit), .idx_o(w_idx));

  assign gnt_valid_o = s_hit || w_hit;
  assign gnt_idx_o   = s_hit ? s_idx : w_idx;
  assign gnt_tail_o  = gnt_valid_o && (gnt_idx_o == QW'(NQ - 1));
  assign gnt_stail_o = gnt_valid_o && stail[gnt_idx_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      round_q <= '0;
      ptr_q   <= '0;
    end else if (!s_hit) begin
      if (w_hit && accept_i) begin
        if (w_idx == QW'(NQ - 1)) begin
          ptr_q   <= '0;
          round_q <= round_q + 1'b1;
        end else begin
          ptr_q   <= w_idx + 1'b1;
        end
      end else if (!w_hit && (|w_pend)) begin
        ptr_q   <= '0;
        round_q <= round_q + 1'b1;
      end
    end
  end

  assert_grant_nonempty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> nonempty_i[gnt_idx_o]);
  assert_zero_weight_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !stat[gnt_idx_o]) |-> (mask[gnt_idx_o] != '0));
  assert_round_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !stat[gnt_idx_o]) |-> mask[gnt_idx_o][round_q]);
  assert_static_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|s_req) |-> (gnt_valid_o && stat[gnt_idx_o]));
  assert_static_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && stat[gnt_idx_o]) |=> ($stable(round_q) && $stable(ptr_q)));
  assert_round_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && (|w_pend)) |=> (round_q == $past(round_q) + 1'b1 && ptr_q == '0));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !accept_i) |=> ($stable(round_q) && $stable(ptr_q)));
endmodule

// File: tb/wrr_sched_tb.sv
module wrr_sched_tb;
  localparam int NQ = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [3:0] cfg_code = '0;
  logic [NQ-1:0] ne = '0;
  logic acc = 1'b0;
  logic gv, gt, gst, err;
  logic [2:0] gi;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  wrr_sched #(.NQ(NQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_code_i(cfg_code), .nonempty_i(ne), .accept_i(acc),
    .gnt_valid_o(gv), .gnt_idx_o(gi), .gnt_tail_o(gt), .gnt_stail_o(gst),
    .cfg_err_o(err)
  );

  // {valid, idx}: queues 1,2,3 with codes 8,1,4, all non-empty, always accepted
  localparam logic [3:0] EXP [24] = '{
    4'h9, 4'hA, 4'hB, 4'h0, 4'h9, 4'h0, 4'h9, 4'hB, 4'h0, 4'h9, 4'h0, 4'h9,
    4'hB, 4'h0, 4'h9, 4'h0, 4'h9, 4'hB, 4'h0, 4'h9, 4'h0, 4'h9, 4'hA, 4'hB};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int q, input int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(q); cfg_code = 4'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at negedge, sample 1 ns later, before the next posedge
  task automatic step(input logic [NQ-1:0] n, input logic a);
    @(negedge clk);
    ne = n; acc = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ne = '0; acc = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R10: all masks zero after reset
    step(8'hFF, 1'b1);
    chk("R10 valid", gv, 0);
    chk("R10 err", err, 0);
    step(8'hFF, 1'b1);
    chk("R10 valid", gv, 0);
    step(8'h00, 1'b0);

    // R1/R6: weighted sweep over eight rounds
    cfg(1, 8); cfg(2, 1); cfg(3, 4);
    for (int k = 0; k < 24; k++) begin
      step(8'h0E, 1'b1);
      chk("R1/R6 valid", gv, EXP[k][3]);
      if (EXP[k][3]) chk("R1/R6 idx", gi, EXP[k][2:0]);
    end

    // R3/R7/R9: static group
    do_reset();
    cfg(0, 9); cfg(1, 9); cfg(2, 8);
    step(8'h07, 1'b0);
    chk("R3 idx", gi, 0); chk("R9 stail", gst, 0); chk("R9 tail", gt, 0);
    step(8'h07, 1'b0);
    chk("R7 hold", gi, 0);
    step(8'h07, 1'b1);
    chk("R3 static stays", gi, 0);
    step(8'h06, 1'b1);
    chk("R3 idx", gi, 1); chk("R9 stail", gst, 1);
    step(8'h06, 1'b1);
    chk("R3 idx", gi, 1);
    step(8'h04, 1'b0);
    chk("R3 weighted after static", gi, 2); chk("R3 valid", gv, 1);
    chk("R4 err", err, 0);
    step(8'h00, 1'b0);

    // R4/R5: configuration errors
    cfg(3, 9); #1 chk("R4 gap", err, 1);
    cfg(3, 0); #1 chk("R4 clear", err, 0);
    cfg(0, 0); #1 chk("R4 not at base", err, 1);
    cfg(1, 12); #1 chk("R5 err", err, 1);
    step(8'h02, 1'b0);
    chk("R5 valid", gv, 1); chk("R5 idx", gi, 1);
    chk("R5 stail", gst, 0);
    step(8'h00, 1'b0);
    cfg(1, 0); cfg(2, 0); #1 chk("R5 clear", err, 0);

    // R2/R8: weight 0 never served
    for (int k = 0; k < 10; k++) begin
      step(8'h20, 1'b1);
      chk("R2 valid", gv, 0);
    end

    // R9: tail flag
    cfg(7, 8);
    step(8'h80, 1'b0);
    chk("R9 valid", gv, 1); chk("R9 idx", gi, 7); chk("R9 tail", gt, 1);
    chk("R9 stail", gst, 0);
    step(8'h00, 1'b0);
    chk("R8 idle", gv, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule